// File: doc/BRIEF.md
# Array Subscript Address Mapper

This block turns the 1-based subscripts of an element in a column-major array of two or three dimensions into the memory address of that element. The caller presents these values and pulses `start` for one cycle:

- the array base address;
- up to three subscripts;
- the first and second dimension ranges;
- the element size in words;
- a mode word.

After a fixed number of cycles, `valid_o` rises and `addr_o` carries the element address. Both then hold until the next accepted start.

Bit 0 of the mode word selects the shape of the array. When it is clear, the array is two-dimensional, and the third subscript and the second range play no part. When it is set, the array is three-dimensional. The other bits of the mode word carry no meaning.

All arithmetic is W-bit two's complement with wraparound. Every product is truncated to W bits. The three products are formed in turn by one shift-and-add multiplier. The third-subscript product is formed even in two-dimensional mode, with a zero operand, so the latency does not depend on the mode.

Top module: `amap_mapper`

## Requirements
- R1: With mode bit 0 clear, the address is base + ((s1-1) + (s2-1)*r1)*size.
- R2: With mode bit 0 set, the address is base + ((s1-1) + ((s3-1)*r2 + (s2-1))*r1)*size.
- R3: Only bit 0 of the mode word selects the form. Bits W-1..1 have no effect on the address.
- R4: In two-dimensional mode, the values of the third subscript and the second range have no effect on the address.
- R5: All sums, differences and products wrap modulo 2^W. A subscript of 0 counts as the value 2^W-1 after its decrement.
- R6: `valid_o` rises exactly 3*W+4 cycles after the cycle in which a start is accepted. `busy_o` is high in the cycles between, and `busy_o` and `valid_o` are never high together.
- R7: Once high, `valid_o` and `addr_o` hold until the next accepted start. `valid_o` is low in the cycle after an accepted start.
- R8: A start pulse while `busy_o` is high is ignored. The running computation keeps its operands and its timing.
- R9: After reset, `valid_o`, `busy_o` and `addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request. It is accepted when the block is not busy. |
| base_i | input | W | Array base address |
| sub1_i | input | W | First subscript, 1-based |
| sub2_i | input | W | Second subscript, 1-based |
| sub3_i | input | W | Third subscript, 1-based (3-D only) |
| rng1_i | input | W | First dimension range |
| rng2_i | input | W | Second dimension range (3-D only) |
| elem_words_i | input | W | Element size in words |
| mode_i | input | W | Mode word. Only bit 0 is used: 0 selects 2-D, 1 selects 3-D. |
| busy_o | output | 1 | Computation in progress |
| valid_o | output | 1 | Address valid and held |
| addr_o | output | W | Element address |

## Verification
The bench builds the block with W = 16, so the latency under test is 52 cycles. The operands needed to reach wraparound stay small enough to write out by hand. A zero subscript and ranges near 2^14 carry the intermediate sums and products past 2^16, which exercises the truncation in every multiply stage. Mode words with the high bits set, and junk in the unused 3-D operands, show that only bit 0 and the named operands steer the result.

// File: rtl/amap_pkg.sv
package amap_pkg;

    // Sequencer phases: one per product formed by the shared multiplier
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL1 = 2'd1,
        ST_MUL2 = 2'd2,
        ST_MUL3 = 2'd3
    } amap_state_e;

    localparam int MUL_STAGES = 3;

endpackage

// File: rtl/amap_prep.sv
// Operand preparation: decrements subscripts and picks first-product operands by mode bit 0
module amap_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] sub1_i,
    input  logic [W-1:0] sub2_i,
    input  logic [W-1:0] sub3_i,
    input  logic [W-1:0] rng2_i,
    output logic [W-1:0] s1m_o,
    output logic [W-1:0] s2m_o,
    output logic [W-1:0] p1_a_o,
    output logic [W-1:0] p1_b_o
);
    logic three_d;
    logic unused_mode_hi;

    assign three_d        = mode_i[0];
    assign unused_mode_hi = ^mode_i[W-1:1];

    always_comb begin
        s1m_o = sub1_i - W'(1);
        s2m_o = sub2_i - W'(1);
        if (three_d) begin
            p1_a_o = sub3_i - W'(1);
            p1_b_o = rng2_i;
        end else begin
            // 2-D: first product forced to zero, timing unchanged
            p1_a_o = '0;
            p1_b_o = '0;
        end
    end

endmodule

// File: rtl/amap_mul.sv
// Serial shift-and-add multiplier, low W bits of the product, W step cycles
module amap_mul #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o,
    output logic         done_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  acc;
        logic [W-1:0]  mc;
        logic [W-1:0]  mp;
    } mul_t;

    mul_t mul_d, mul_q;

    always_comb begin
        mul_d      = mul_q;
        mul_d.done = 1'b0;
        if (load_i) begin
            mul_d.busy = 1'b1;
            mul_d.cnt  = '0;
            mul_d.acc  = '0;
            mul_d.mc   = a_i;
            mul_d.mp   = b_i;
        end else if (mul_q.busy) begin
            if (mul_q.mp[0]) begin
                mul_d.acc = mul_q.acc + mul_q.mc;
            end
            mul_d.mc  = mul_q.mc << 1;
            mul_d.mp  = mul_q.mp >> 1;
            mul_d.cnt = mul_q.cnt + CW'(1);
            if (mul_q.cnt == CW'(W - 1)) begin
                mul_d.busy = 1'b0;
                mul_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_q <= '0;
        end else begin
            mul_q <= mul_d;
        end
    end

    assign prod_o = mul_q.acc;
    assign done_o = mul_q.done;

endmodule

// File: rtl/amap_mapper.sv
// Array subscript address mapper top: sequences three products on one multiplier
module amap_mapper #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] sub1_i,
    input  logic [W-1:0] sub2_i,
    input  logic [W-1:0] sub3_i,
    input  logic [W-1:0] rng1_i,
    input  logic [W-1:0] rng2_i,
    input  logic [W-1:0] elem_words_i,
    input  logic [W-1:0] mode_i,
    output logic         busy_o,
    output logic         valid_o,
    output logic [W-1:0] addr_o
);
    import amap_pkg::*;

    typedef struct packed {
        amap_state_e  state;
        logic [W-1:0] s1m;
        logic [W-1:0] s2m;
        logic [W-1:0] r1;
        logic [W-1:0] sz;
        logic [W-1:0] base;
        logic [W-1:0] addr;
        logic         valid;
    } map_t;

    map_t map_d, map_q;

    logic [W-1:0] pre_s1m, pre_s2m, pre_a, pre_b;
    logic         mul_load, mul_done;
    logic [W-1:0] mul_a, mul_b, mul_prod;

    amap_prep #(.W(W)) u_prep (
        .mode_i (mode_i),
        .sub1_i (sub1_i),
        .sub2_i (sub2_i),
        .sub3_i (sub3_i),
        .rng2_i (rng2_i),
        .s1m_o  (pre_s1m),
        .s2m_o  (pre_s2m),
        .p1_a_o (pre_a),
        .p1_b_o (pre_b)
    );

    amap_mul #(.W(W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mul_load),
        .a_i    (mul_a),
        .b_i    (mul_b),
        .prod_o (mul_prod),
        .done_o (mul_done)
    );

    always_comb begin
        map_d    = map_q;
        mul_load = 1'b0;
        mul_a    = '0;
        mul_b    = '0;
        unique case (map_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    map_d.s1m   = pre_s1m;
                    map_d.s2m   = pre_s2m;
                    map_d.r1    = rng1_i;
                    map_d.sz    = elem_words_i;
                    map_d.base  = base_i;
                    map_d.valid = 1'b0;
                    mul_load    = 1'b1;
                    mul_a       = pre_a;
                    mul_b       = pre_b;
                    map_d.state = ST_MUL1;
                end
            end
            ST_MUL1: begin
                if (mul_done) begin
                    mul_load    = 1'b1;
                    mul_a       = mul_prod + map_q.s2m;
                    mul_b       = map_q.r1;
                    map_d.state = ST_MUL2;
                end
            end
            ST_MUL2: begin
                if (mul_done) begin
                    mul_load    = 1'b1;
                    mul_a       = mul_prod + map_q.s1m;
                    mul_b       = map_q.sz;
                    map_d.state = ST_MUL3;
                end
            end
            ST_MUL3: begin
                if (mul_done) begin
                    map_d.addr  = map_q.base + mul_prod;
                    map_d.valid = 1'b1;
                    map_d.state = ST_IDLE;
                end
            end
            default: map_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign busy_o  = (map_q.state != ST_IDLE);
    assign valid_o = map_q.valid;
    assign addr_o  = map_q.addr;

endmodule

// File: rtl/amap_mapper_chk.sv
// Protocol checker for amap_mapper, bound to every instance
module amap_mapper_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         valid_o,
    input logic [W-1:0] addr_o
);
    localparam int LAT   = 3 * W + 4;
    localparam int LAT_W = $clog2(LAT + 1) + 1;

    logic [LAT_W-1:0] lat_q;

    // Cycles since the last accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            lat_q <= LAT_W'(1);
        end else if (busy_o) begin
            lat_q <= lat_q + LAT_W'(1);
        end
    end

    // R6: busy and valid are exclusive
    p_busy_valid_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && valid_o));

    // R6: result appears exactly LAT cycles after an accepted start
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (lat_q == LAT_W'(LAT)));

    // R7: an accepted start drops valid and raises busy
    p_start_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !valid_o));

    // R7: result held while no start arrives
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i) |=> (valid_o && $stable(addr_o)));

    // R8: start during busy does not abort the computation
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || valid_o));

endmodule

bind amap_mapper amap_mapper_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .addr_o  (addr_o)
);

// File: tb/amap_mapper_tb.sv
module amap_mapper_tb;
    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3 * W + 4;

    logic         clk;
    logic         rst_n;
    logic         start_i;
    logic [W-1:0] base_i, sub1_i, sub2_i, sub3_i, rng1_i, rng2_i, elem_words_i, mode_i;
    logic         busy_o, valid_o;
    logic [W-1:0] addr_o;

    amap_mapper #(.W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .base_i       (base_i),
        .sub1_i       (sub1_i),
        .sub2_i       (sub2_i),
        .sub3_i       (sub3_i),
        .rng1_i       (rng1_i),
        .rng2_i       (rng2_i),
        .elem_words_i (elem_words_i),
        .mode_i       (mode_i),
        .busy_o       (busy_o),
        .valid_o      (valid_o),
        .addr_o       (addr_o)
    );

    int           cyc;
    int           errors;
    int           checks;
    int           start_cyc;
    string        cur_req;
    logic [W-1:0] exp_q[$];
    logic         prev_valid;
    bit           finished;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    initial cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference from the requirement formulas (W-bit wraparound)
    function automatic logic [W-1:0] model(input logic [W-1:0] b, s1, s2, s3, r1, r2, sz, md);
        logic [W-1:0] off;
        logic [W-1:0] plane;
        if (md[0]) begin
            plane = (s3 - W'(1)) * r2;
            off   = (s1 - W'(1)) + (plane + (s2 - W'(1))) * r1;
        end else begin
            off   = (s1 - W'(1)) + (s2 - W'(1)) * r1;
        end
        return b + off * sz;
    endfunction

    // Monitor: pop on each rising valid, compare address and latency
    always @(negedge clk) begin
        if (rst_n && valid_o && !prev_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " unexpected result"}, int'(addr_o), 0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                check(addr_o == e, {cur_req, " address"}, int'(addr_o), int'(e));
                check((cyc - start_cyc) == LAT, "R6 latency", cyc - start_cyc, LAT);
            end
        end
        prev_valid = valid_o;
    end

    task automatic drive(input string req, input logic [W-1:0] b, s1, s2, s3, r1, r2, sz, md);
        @(negedge clk);
        base_i = b; sub1_i = s1; sub2_i = s2; sub3_i = s3;
        rng1_i = r1; rng2_i = r2; elem_words_i = sz; mode_i = md;
        start_i   = 1'b1;
        cur_req   = req;
        start_cyc = cyc;
        exp_q.push_back(model(b, s1, s2, s3, r1, r2, sz, md));
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !valid_o, "R6/R7 busy after start", {busy_o, valid_o}, 2);
    endtask

    task automatic wait_done();
        while (!valid_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input string req, input logic [W-1:0] b, s1, s2, s3, r1, r2, sz, md);
        drive(req, b, s1, s2, s3, r1, r2, sz, md);
        wait_done();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        errors = 0; checks = 0; finished = 0; prev_valid = 1'b0;
        start_cyc = 0; cur_req = "none";
        rst_n = 1'b0; start_i = 1'b0;
        base_i = '0; sub1_i = '0; sub2_i = '0; sub3_i = '0;
        rng1_i = '0; rng2_i = '0; elem_words_i = '0; mode_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(!valid_o, "R9 valid", int'(valid_o), 0);
        check(!busy_o, "R9 busy", int'(busy_o), 0);
        check(addr_o == '0, "R9 addr", int'(addr_o), 0);

        // R1 two-dimensional
        run("R1", 16'h1000, 16'd3, 16'd2, 16'd0, 16'd10, 16'd0, 16'd2, 16'h0000);
        check(addr_o == 16'h1018, "R1 known value", int'(addr_o), 16'h1018);
        run("R1", 16'h0100, 16'd1, 16'd1, 16'd9, 16'd7, 16'd3, 16'd4, 16'h0000);
        run("R1", 16'h0040, 16'd5, 16'd4, 16'd0, 16'd3, 16'd0, 16'd0, 16'h0000);

        // R2 three-dimensional
        run("R2", 16'h2000, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd3, 16'h0001);
        check(addr_o == 16'h212F, "R2 known value", int'(addr_o), 16'h212F);
        run("R2", 16'h0000, 16'd1, 16'd1, 16'd1, 16'd8, 16'd8, 16'd1, 16'h0001);

        // R3 only bit 0 of the mode word matters
        run("R3", 16'h1000, 16'd3, 16'd2, 16'd4, 16'd10, 16'd6, 16'd2, 16'hFFFE);
        check(addr_o == 16'h1018, "R3 high bits ignored", int'(addr_o), 16'h1018);
        run("R3", 16'h2000, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd3, 16'h8003);
        check(addr_o == 16'h212F, "R3 3-D with high bits", int'(addr_o), 16'h212F);

        // R4 third subscript and second range unused in 2-D
        run("R4", 16'h1000, 16'd3, 16'd2, 16'h1234, 16'd10, 16'h0777, 16'd2, 16'h0000);
        check(addr_o == 16'h1018, "R4 3-D operands ignored", int'(addr_o), 16'h1018);

        // R5 wraparound
        run("R5", 16'h0000, 16'd0, 16'd1, 16'd0, 16'd5, 16'd0, 16'd1, 16'h0000);
        check(addr_o == 16'hFFFF, "R5 zero subscript", int'(addr_o), 16'hFFFF);
        run("R5", 16'h0300, 16'd1, 16'd5, 16'd0, 16'h4000, 16'd0, 16'd1, 16'h0000);
        check(addr_o == 16'h0300, "R5 product wraps", int'(addr_o), 16'h0300);
        run("R5", 16'hFFF0, 16'h8001, 16'd7, 16'd300, 16'h3FFF, 16'h0123, 16'd5, 16'h0001);

        // R7 hold with changing inputs and no start
        begin
            logic [W-1:0] held;
            held = addr_o;
            base_i = 16'hABCD; sub1_i = 16'd99; mode_i = 16'h0001;
            repeat (20) @(negedge clk);
            check(valid_o && addr_o == held, "R7 hold", int'(addr_o), int'(held));
        end

        // R8 start while busy is ignored
        drive("R8", 16'h0500, 16'd4, 16'd2, 16'd0, 16'd6, 16'd0, 16'd1, 16'h0000);
        repeat (10) @(negedge clk);
        base_i = 16'h7777; sub1_i = 16'd50; rng1_i = 16'd9; mode_i = 16'h0001;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R8 still busy", int'(busy_o), 1);
        wait_done();
        check(addr_o == 16'h0509, "R8 first operands kept", int'(addr_o), 16'h0509);
        check(exp_q.size() == 0, "R8 no extra result", exp_q.size(), 0);

        repeat (5) @(negedge clk);
        check(valid_o && !busy_o, "R7 idle after result", {valid_o, busy_o}, 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule